// File: doc/BRIEF.md
# Receive-Complete Flag Register

This block holds one sticky status bit for each of sixteen message buffers in a message controller. When the receive path has finished storing a message into buffer x, it pulses bit x of a one-cycle event vector, and flag x latches high. Software sees the flags over a byte-addressable register port with a lower byte (flags 7..0) and an upper byte (flags 15..8). It acknowledges a buffer by writing zero to that buffer's flag.

Writing one to a flag does nothing. A read that is tagged as part of a read-modify-write returns all ones, so a read-modify-write that clears one flag cannot clear any other flag by accident. A sixteen-bit enable vector masks the flags onto a single registered interrupt request. The controller can be instantiated up to five times. A parameter picks the instance, and the instance fixes the byte addresses at which this copy responds.

Top module: `rxdone_status`

## Requirements
- R1: While reset is high at a clock edge, all sixteen flags clear to 0 and `irq_req` goes low at that edge.
- R2: A 1 on `rx_done[x]` in one cycle sets flag x at the next clock edge. Several bits may pulse in the same cycle, and a flag that is already set stays set. No flag rises without its event bit.
- R3: A register write with byte-enable bit 0 set writes flags 7..0 from `bus_wdata[7:0]`. Byte-enable bit 1 selects flags 15..8 from `bus_wdata[15:8]`. Each data bit that is 0 clears its flag at the next edge.
- R4: A data bit of 1 in a write leaves its flag unchanged.
- R5: Flags in a byte lane whose enable bit is 0 are not changed by a write, whatever the data.
- R6: A read with `bus_rmw` low returns the current flags on `bus_rdata` in the same cycle. Reads never change a flag, and no flag clears without a write.
- R7: A read with `bus_rmw` high returns 16'hFFFF. Writing that value back clears nothing.
- R8: When an event sets bit x in the same cycle as a write of 0 to bit x, the flag is 1 after the edge.
- R9: `irq_req` is a register that holds the OR over all x of (flag x AND `irq_en[x]`), taken at the previous edge. It rises one cycle after the first contributing flag sets, and it falls one cycle after the last one clears.
- R10: The block responds only when `bus_addr` with bit 0 ignored equals the instance base address. The base is 16'h0078 for instance 0 and 16'h0088 for instance 1. For instances 2 to 4 it is 16'h3578 plus 16'h10 per step. Both the base address and base+1 address the register. Writes elsewhere are ignored, and `bus_rdata` is 0 whenever no matching read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as the first half of a read-modify-write |
| bus_be | input | 2 | Byte enables: bit 0 lower flags, bit 1 upper flags |
| bus_wdata | input | 16 | Write data; 0 clears, 1 keeps |
| bus_rdata | output | 16 | Read data, combinational |
| rx_done | input | 16 | Per-buffer receive-complete pulses |
| irq_en | input | 16 | Per-buffer interrupt enables |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The hardware set and the software clear can hit the same flag in the same cycle. The bench provokes this by driving an event pulse on a bit while a write of zero to every bit is active in that same cycle. It then reads the register back and expects the pulsed bit to be 1 and all other bits to be 0, so the set must win over the clear. An assertion checks the same rule on every cycle in which an event coincides with a write.

// File: rtl/rxdone_pkg.sv
package rxdone_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int FLAG_W    = BYTE_W * NUM_LANES;
    localparam int MAX_INST  = 5;

    typedef logic [FLAG_W-1:0]    flag_vec_t;
    typedef logic [NUM_LANES-1:0] lane_vec_t;

    typedef struct packed {
        logic      wr;
        logic      rd;
        logic      rmw;
        lane_vec_t be;
        flag_vec_t wdata;
    } bus_req_t;

    // Even base address of the register pair for a given controller copy.
    function automatic logic [31:0] inst_base(int unsigned sel);
        if (sel < 2)
            return 32'h0000_0078 + 32'(sel) * 32'h10;
        else
            return 32'h0000_3578 + 32'(sel - 2) * 32'h10;
    endfunction

endpackage

// File: rtl/rxdone_decode.sv
module rxdone_decode
    import rxdone_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int unsigned INST_SEL = 0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  bus_req_t          req,
    output logic              wr_hit,
    output logic              rd_hit,
    output flag_vec_t         clr_mask
);
    localparam logic [31:0]       BASE32   = inst_base(INST_SEL);
    localparam logic [ADDR_W-1:0] BASE_ODD = ADDR_W'(BASE32 | 32'h1);

    logic addr_hit;

    // Bit 0 only picks the byte; forcing it high matches both addresses.
    assign addr_hit = ((bus_addr | ADDR_W'(1)) == BASE_ODD);
    assign wr_hit   = addr_hit & req.wr;
    assign rd_hit   = addr_hit & req.rd;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign clr_mask[g*BYTE_W +: BYTE_W] =
            {BYTE_W{wr_hit & req.be[g]}} & ~req.wdata[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/rxdone_flags.sv
module rxdone_flags
    import rxdone_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_mask,
    output flag_vec_t flags
);
    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags[b] <= 1'b0;
            else if (set_vec[b])
                flags[b] <= 1'b1;   // event beats a same-cycle clear
            else if (clr_mask[b])
                flags[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/rxdone_irq.sv
module rxdone_irq
    import rxdone_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t flags,
    input  flag_vec_t enables,
    output logic      irq_q
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(flags & enables);
    end

endmodule

// File: rtl/rxdone_chk.sv
module rxdone_chk
    import rxdone_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bus_wr,
    input logic      bus_rd,
    input logic      bus_rmw,
    input flag_vec_t bus_rdata,
    input flag_vec_t rx_done,
    input flag_vec_t irq_en,
    input logic      irq_req,
    input flag_vec_t flags
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flags == '0 && !irq_req)); // R1

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (rx_done != '0) |=> ((flags & $past(rx_done)) == $past(rx_done))); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_done == '0) |=> ((flags & ~$past(flags)) == '0)); // R2

    AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ((~flags & $past(flags)) == '0)); // R6

    AST_PLAIN_READ_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_rmw && bus_rdata != '0) |-> (bus_rdata == flags)); // R6

    AST_RMW_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_rmw && bus_rdata != '0) |-> (bus_rdata == '1)); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && rx_done != '0) |=> ((flags & $past(rx_done)) == $past(rx_done))); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (irq_req == |($past(flags) & $past(irq_en)))); // R9

endmodule

// File: rtl/rxdone_status.sv
module rxdone_status
    import rxdone_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int unsigned INST_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       rx_done,
    input  logic [15:0]       irq_en,
    output logic              irq_req
);
    bus_req_t  req;
    logic      wr_hit;
    logic      rd_hit;
    flag_vec_t clr_mask;
    flag_vec_t flags;

    initial begin
        if (INST_SEL >= MAX_INST)
            $error("INST_SEL out of range");
    end

    assign req = '{wr: bus_wr, rd: bus_rd, rmw: bus_rmw,
                   be: bus_be, wdata: bus_wdata};

    rxdone_decode #(
        .ADDR_W   (ADDR_W),
        .INST_SEL (INST_SEL)
    ) u_decode (
        .bus_addr (bus_addr),
        .req      (req),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit),
        .clr_mask (clr_mask)
    );

    rxdone_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (rx_done),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    rxdone_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .enables (irq_en),
        .irq_q   (irq_req)
    );

    // Read-modify-write reads return ones so a write-back clears nothing.
    always_comb begin
        if (!rd_hit)
            bus_rdata = '0;
        else if (req.rmw)
            bus_rdata = '1;
        else
            bus_rdata = flags;
    end

endmodule

bind rxdone_status rxdone_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rmw   (bus_rmw),
    .bus_rdata (bus_rdata),
    .rx_done   (rx_done),
    .irq_en    (irq_en),
    .irq_req   (irq_req),
    .flags     (flags)
);

// File: tb/sim_rxdone_status.sv
module sim_rxdone_status;

    localparam logic [15:0] BASE = 16'h0078;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd, bus_rmw;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata, bus_rdata, rx_done, irq_en;
    logic        irq_req;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    rxdone_status #(.ADDR_W(16), .INST_SEL(0)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rmw(bus_rmw), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_done(rx_done),
        .irq_en(irq_en), .irq_req(irq_req)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(logic [15:0] v);
        rx_done = v;
        step();
        rx_done = '0;
    endtask

    task automatic wr(logic [15:0] a, logic [1:0] be, logic [15:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_be = '0; bus_wdata = '0; bus_addr = BASE;
    endtask

    task automatic rd(logic [15:0] a, logic rmw, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0; bus_rmw = 1'b0; bus_addr = BASE;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq after reset", {15'b0, irq_req}, 16'h0000);
        check("R10 rdata idle", bus_rdata, 16'h0000);
        rd(BASE, 1'b0, v);
        check("R1 flags after reset", v, 16'h0000);
    endtask

    task automatic t_set_multi();
        logic [15:0] v;
        pulse(16'h8421);
        rd(BASE, 1'b0, v);
        check("R2 multi-bit set", v, 16'h8421);
        pulse(16'h0003);
        rd(BASE, 1'b0, v);
        check("R2 set accumulates", v, 16'h8423);
    endtask

    task automatic t_clear_and_ones();
        logic [15:0] v;
        wr(BASE, 2'b11, 16'hFFDF);
        rd(BASE, 1'b0, v);
        check("R3 zero clears bit 5", v, 16'h8403);
        wr(BASE, 2'b11, 16'hFFFF);
        rd(BASE, 1'b0, v);
        check("R4 ones keep flags", v, 16'h8403);
    endtask

    task automatic t_byte_lanes();
        logic [15:0] v;
        wr(BASE, 2'b01, 16'h0000);
        rd(BASE, 1'b0, v);
        check("R5 lower-only write", v, 16'h8400);
        pulse(16'h00F0);
        wr(BASE + 16'h1, 2'b10, 16'h0000);
        rd(BASE, 1'b0, v);
        check("R5 upper-only write", v, 16'h00F0);
        wr(BASE, 2'b01, 16'h000F);
        rd(BASE, 1'b0, v);
        check("R3 lower lane clears", v, 16'h0000);
    endtask

    task automatic t_read_no_side();
        logic [15:0] v;
        pulse(16'h1234);
        rd(BASE, 1'b0, v);
        check("R6 read value", v, 16'h1234);
        step();
        rd(BASE, 1'b0, v);
        check("R6 read has no side effect", v, 16'h1234);
    endtask

    task automatic t_rmw();
        logic [15:0] v;
        rd(BASE, 1'b1, v);
        check("R7 rmw read ones", v, 16'hFFFF);
        wr(BASE, 2'b11, v);
        rd(BASE, 1'b0, v);
        check("R7 write-back clears nothing", v, 16'h1234);
        wr(BASE, 2'b11, 16'hFFFB);
        rd(BASE, 1'b0, v);
        check("R7 rmw clears only bit 2", v, 16'h1230);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        rx_done = 16'h0010;
        wr(BASE, 2'b11, 16'h0000);
        rx_done = '0;
        rd(BASE, 1'b0, v);
        check("R8 set wins over clear", v, 16'h0010);
    endtask

    task automatic t_address();
        logic [15:0] v;
        wr(16'h0088, 2'b11, 16'h0000);
        rd(BASE, 1'b0, v);
        check("R10 foreign write ignored", v, 16'h0010);
        rd(16'h007A, 1'b0, v);
        check("R10 foreign read zero", v, 16'h0000);
        rd(16'h0079, 1'b0, v);
        check("R10 odd address reads", v, 16'h0010);
        wr(16'h0079, 2'b11, 16'h0000);
        rd(BASE, 1'b0, v);
        check("R10 odd address writes", v, 16'h0000);
    endtask

    task automatic t_irq();
        irq_en = 16'h0100;
        step();
        check("R9 idle irq", {15'b0, irq_req}, 16'h0000);
        pulse(16'h0001);
        step();
        check("R9 masked flag", {15'b0, irq_req}, 16'h0000);
        pulse(16'h0100);
        check("R9 irq one cycle late", {15'b0, irq_req}, 16'h0000);
        step();
        check("R9 irq rises", {15'b0, irq_req}, 16'h0001);
        wr(BASE + 16'h1, 2'b10, 16'h0000);
        check("R9 irq holds a cycle", {15'b0, irq_req}, 16'h0001);
        step();
        check("R9 irq falls", {15'b0, irq_req}, 16'h0000);
        irq_en = 16'h0001;
        step();
        check("R9 enable gates flag 0", {15'b0, irq_req}, 16'h0001);
        irq_en = '0;
        step();
        check("R9 enable removed", {15'b0, irq_req}, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = BASE; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_rmw = 1'b0; bus_be = '0; bus_wdata = '0; rx_done = '0; irq_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_multi();
        t_clear_and_ones();
        t_byte_lanes();
        t_read_no_side();
        t_rmw();
        t_collision();
        t_address();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule